// File: doc/BRIEF.md
# Four-Common Multiplexed LCD Segment Driver

This block drives a passive LCD panel with four common electrodes and twenty segment electrodes, using 1/4 duty and 1/2 bias. The clock input is the 75 kHz timebase, and the block divides it into 75 Hz frames. Each frame has eight slots. Every common is selected once with positive polarity and once with negative polarity, so no pixel sees a net DC voltage over a frame. The pins do not carry analog voltages. Each pin gives a 2-bit level code, and an external analog stage turns that code into a supply, middle or ground voltage. Codes: `00` low, `01` middle, `10` high, `11` released (the pin belongs to a general-purpose port and the driver does not drive it).

The display pattern is stored per digit. Digit *d* is segment pin *d*, and bit *c* of its 4-bit pattern is the pixel where segment *d* crosses common *c*. Patterns arrive on a valid/ready write stream. A write in direct mode changes the shown pattern at once. A write in latched mode goes into a shadow copy, and a transfer request commits the whole shadow copy at the next frame boundary. Segment pins 12..15 and 16..19 can each be handed to general-purpose I/O one bit at a time through two 4-bit configuration words. A backup input forces the panel to a safe low state.

Stream rules: a write is accepted on a rising edge where `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` is low, the producer keeps digit, pattern and mode steady. Direct writes are never stalled. Latched writes stall while a transfer is pending. A write to a digit index of 20 or more is accepted and dropped. The outputs are registered: the code present after a clock edge reflects the slot, pattern and controls that held before that edge.

Top module: `lcd_mux_driver`

## Requirements
- R1: While `rst_n` is low, every common and segment code becomes `00`, `port_in_en` becomes 0 and both configuration words clear to 0, so all shared pins are segments. The stored patterns clear to zero and no transfer is pending.
- R2: After reset is released, every common and segment code stays `00` for the first full frame (1000 clocks). The waveform starts with the following frame and never blanks again until the next reset.
- R3: A frame is 8 slots of 125 clocks. Slot *s* selects common *s* mod 4. Slots 0..3 are the positive half and slots 4..7 are the negative half.
- R4: The selected common drives `10` in the positive half and `00` in the negative half. The three unselected commons drive `01`.
- R5: A segment whose pixel bit for the selected common is 1 drives the rail opposite to the selected common (`00` in the positive half, `10` in the negative half). A segment whose bit is 0 drives the same rail as the selected common. Segments never drive `01`.
- R6: A direct write (`wr_mode`=0) replaces that digit's shown pattern. The new pattern appears in the codes from the second edge after acceptance.
- R7: A latched write (`wr_mode`=1) has no effect on the codes until a transfer. A `xfer_req` pulse sets a pending transfer. The pending transfer copies all shadow patterns to the display on the last clock of the current frame, and never earlier.
- R8: `wr_ready` is low for latched writes while a transfer is pending, and the shadow copy is then frozen. `wr_ready` is always high for direct writes.
- R9: A configuration write (`cfg_we`) loads `cfg_bits` into word `cfg_grp`. Word 0 covers segment pins 12..15 and word 1 covers 16..19, bit *i* for the *i*-th pin of the group. A 1 releases the pin: its code becomes `11` and its `port_in_en` becomes 1. A 0 keeps the pin as a segment.
- R10: While `backup` is high, all commons and non-released segments drive `00`, and every `port_in_en` drops to 0. Released pins stay `11`. This takes effect one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 75 kHz timebase |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Pattern write valid |
| wr_ready | output | 1 | Pattern write ready |
| wr_mode | input | 1 | 0 = direct to display, 1 = into shadow copy |
| wr_digit | input | 5 | Digit (segment pin) index |
| wr_pattern | input | 4 | Pixel bits, bit c for common c |
| xfer_req | input | 1 | Request to commit the shadow copy at the next frame boundary |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_grp | input | 1 | Configuration word select |
| cfg_bits | input | 4 | Configuration word value, 1 = port |
| backup | input | 1 | Backup mode force |
| com_lvl | output | 8 | Level codes of the four commons, common c at bits 2c+1:2c |
| seg_lvl | output | 40 | Level codes of the twenty segments, segment d at bits 2d+1:2d |
| port_in_en | output | 8 | Input enable of the released shared pins 12..19 |

## Verification
The bench models every code on every clock against the frame arithmetic. It goes after these boundaries:
- The end of the blank first frame. A design that starts early or late shows codes in the wrong slot.
- The polarity flip at slot 4. Getting it wrong leaves DC on the pixels.
- The exact commit clock of a latched transfer. A design that copies at once would tear the frame mid-scan.
- A latched write offered while a transfer is pending. A design without the stall would leak the stalled pattern into the committed frame.
- Released pins in normal, backup and reset states. A pin that keeps driving, or keeps its input enabled in backup, is caught at the ports.
- A sweep of all sixteen patterns on one digit across both halves of the frame. It exposes any swapped rail or wrong bit select.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_OFF  = 2'b11
  } lvl_e;

endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
  parameter int CLKS_PER_SLOT = 125,
  parameter int SLOTS         = 8,
  localparam int CW = (CLKS_PER_SLOT > 1) ? $clog2(CLKS_PER_SLOT) : 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot_o,
  output logic          frame_end_o,
  output logic          running_o
);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] slot_q;
  logic          run_q;
  logic          slot_end;

  assign slot_end    = (cnt_q == CW'(CLKS_PER_SLOT - 1));
  assign frame_end_o = slot_end && (slot_q == SW'(SLOTS - 1));
  assign slot_o      = slot_q;
  assign running_o   = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (slot_end) begin
        cnt_q  <= '0;
        slot_q <= (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (frame_end_o) run_q <= 1'b1;
    end
  end

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q); // R2

  AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(slot_q)); // R3

endmodule

// File: rtl/lcd_pattern_store.sv
module lcd_pattern_store #(
  parameter int NUM_SEG = 20,
  parameter int NUM_COM = 4,
  localparam int AW = $clog2(NUM_SEG)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid,
  output logic                             wr_ready,
  input  logic                             wr_mode,
  input  logic [AW-1:0]                    wr_digit,
  input  logic [NUM_COM-1:0]               wr_pattern,
  input  logic                             xfer_req,
  input  logic                             frame_end,
  output logic [NUM_SEG-1:0][NUM_COM-1:0]  disp_o
);

  logic [NUM_SEG-1:0][NUM_COM-1:0] disp_q;
  logic [NUM_SEG-1:0][NUM_COM-1:0] shad_q;
  logic                            pend_q;
  logic                            fire;
  logic                            in_range;

  assign wr_ready = !(wr_mode && pend_q);
  assign fire     = wr_valid && wr_ready;
  assign in_range = (int'(wr_digit) < NUM_SEG);
  assign disp_o   = disp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_q <= '0;
      shad_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (frame_end && pend_q) begin
        disp_q <= shad_q;
        pend_q <= 1'b0;
      end else if (xfer_req) begin
        pend_q <= 1'b1;
      end
      if (fire && in_range) begin
        if (wr_mode) shad_q[wr_digit] <= wr_pattern;
        else         disp_q[wr_digit] <= wr_pattern;
      end
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !frame_end) |=> pend_q); // R7

  AST_DISP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !(fire && !wr_mode)) |=> $stable(disp_q)); // R7

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> $stable(shad_q)); // R8

endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
  import lcd_pkg::*;
#(
  parameter int NUM_SEG     = 20,
  parameter int NUM_COM     = 4,
  parameter int SHARED_BASE = 12,
  parameter int NUM_SHARED  = 8,
  localparam int SLOTS = 2 * NUM_COM,
  localparam int SW    = $clog2(SLOTS),
  localparam int SELW  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SW-1:0]                    slot_i,
  input  logic                             running_i,
  input  logic                             backup_i,
  input  logic [NUM_SEG-1:0][NUM_COM-1:0]  disp_i,
  input  logic [NUM_SHARED-1:0]            port_cfg_i,
  output logic [2*NUM_COM-1:0]             com_lvl_o,
  output logic [2*NUM_SEG-1:0]             seg_lvl_o,
  output logic [NUM_SHARED-1:0]            port_in_en_o
);

  logic                       neg_half;
  logic [SELW-1:0]            sel_com;
  logic                       blank;
  logic [1:0]                 rail_sel;
  logic [1:0]                 rail_opp;
  logic [NUM_COM-1:0][1:0]    com_n, com_q;
  logic [NUM_SEG-1:0][1:0]    seg_n, seg_q;
  logic [NUM_SHARED-1:0]      pin_n, pin_q;
  logic [NUM_COM-1:0]         com_driven;

  assign neg_half = (slot_i >= SW'(NUM_COM));
  assign sel_com  = SELW'(neg_half ? slot_i - SW'(NUM_COM) : slot_i);
  assign blank    = backup_i || !running_i;
  assign rail_sel = neg_half ? LVL_LOW  : LVL_HIGH;
  assign rail_opp = neg_half ? LVL_HIGH : LVL_LOW;
  assign pin_n    = port_cfg_i & ~{NUM_SHARED{backup_i}};

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    assign com_n[c]      = blank ? LVL_LOW
                         : ((sel_com == SELW'(c)) ? rail_sel : LVL_MID);
    assign com_driven[c] = (com_q[c] != LVL_MID);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic       pix;
    logic [1:0] wave;
    assign pix  = disp_i[s][sel_com];
    assign wave = blank ? LVL_LOW : (pix ? rail_opp : rail_sel);
    if (s >= SHARED_BASE && s < SHARED_BASE + NUM_SHARED) begin : g_shared
      assign seg_n[s] = port_cfg_i[s - SHARED_BASE] ? LVL_OFF : wave;
      AST_PORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        port_cfg_i[s - SHARED_BASE] |=> (seg_q[s] == LVL_OFF)); // R9
    end else begin : g_fixed
      assign seg_n[s] = wave;
      AST_SEG_TWO_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q[s] != LVL_MID) && (seg_q[s] != LVL_OFF)); // R5
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      com_q <= '0;
      seg_q <= '0;
      pin_q <= '0;
    end else begin
      com_q <= com_n;
      seg_q <= seg_n;
      pin_q <= pin_n;
    end
  end

  assign com_lvl_o    = com_q;
  assign seg_lvl_o    = seg_q;
  assign port_in_en_o = pin_q;

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (com_q == '0 && seg_q == '0 && pin_q == '0)); // R1

  AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running_i |=> (com_q == '0)); // R2

  AST_ONE_COM_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running_i) && !$past(backup_i)) |-> ($countones(com_driven) == 1)); // R4

  AST_BACKUP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    backup_i |=> (com_q == '0)); // R10

  AST_BACKUP_IN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    backup_i |=> (pin_q == '0)); // R10

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver #(
  parameter int CLKS_PER_SLOT = 125,
  parameter int NUM_COM       = 4,
  parameter int NUM_SEG       = 20,
  parameter int SHARED_BASE   = 12,
  parameter int SHARED_GROUPS = 2,
  parameter int GROUP_W       = 4,
  localparam int SLOTS      = 2 * NUM_COM,
  localparam int SW         = $clog2(SLOTS),
  localparam int AW         = $clog2(NUM_SEG),
  localparam int NUM_SHARED = SHARED_GROUPS * GROUP_W,
  localparam int GSEL_W     = (SHARED_GROUPS > 1) ? $clog2(SHARED_GROUPS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic                    wr_mode,
  input  logic [AW-1:0]           wr_digit,
  input  logic [NUM_COM-1:0]      wr_pattern,
  input  logic                    xfer_req,
  input  logic                    cfg_we,
  input  logic [GSEL_W-1:0]       cfg_grp,
  input  logic [GROUP_W-1:0]      cfg_bits,
  input  logic                    backup,
  output logic [2*NUM_COM-1:0]    com_lvl,
  output logic [2*NUM_SEG-1:0]    seg_lvl,
  output logic [NUM_SHARED-1:0]   port_in_en
);

  logic [SW-1:0]                      slot;
  logic                               frame_end;
  logic                               running;
  logic [NUM_SEG-1:0][NUM_COM-1:0]    disp;
  logic [SHARED_GROUPS-1:0][GROUP_W-1:0] cfg_q;
  logic [NUM_SHARED-1:0]              port_cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we && (int'(cfg_grp) < SHARED_GROUPS)) begin
      cfg_q[cfg_grp] <= cfg_bits;
    end
  end

  assign port_cfg = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q)); // R9

  lcd_timebase #(
    .CLKS_PER_SLOT (CLKS_PER_SLOT),
    .SLOTS         (SLOTS)
  ) u_timebase (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_o      (slot),
    .frame_end_o (frame_end),
    .running_o   (running)
  );

  lcd_pattern_store #(
    .NUM_SEG (NUM_SEG),
    .NUM_COM (NUM_COM)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_mode    (wr_mode),
    .wr_digit   (wr_digit),
    .wr_pattern (wr_pattern),
    .xfer_req   (xfer_req),
    .frame_end  (frame_end),
    .disp_o     (disp)
  );

  lcd_wave_gen #(
    .NUM_SEG     (NUM_SEG),
    .NUM_COM     (NUM_COM),
    .SHARED_BASE (SHARED_BASE),
    .NUM_SHARED  (NUM_SHARED)
  ) u_wave (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_i       (slot),
    .running_i    (running),
    .backup_i     (backup),
    .disp_i       (disp),
    .port_cfg_i   (port_cfg),
    .com_lvl_o    (com_lvl),
    .seg_lvl_o    (seg_lvl),
    .port_in_en_o (port_in_en)
  );

endmodule

// File: tb/lcd_mux_driver_bench.sv
module lcd_mux_driver_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCOM  = 4;
  localparam int NSEG  = 20;
  localparam int SLOT  = 125;
  localparam int FRAME = 8 * SLOT;
  localparam int SHB   = 12;
  localparam int NSH   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic              wr_mode = 1'b0;
  logic [4:0]        wr_digit = '0;
  logic [3:0]        wr_pattern = '0;
  logic              xfer_req = 1'b0;
  logic              cfg_we = 1'b0;
  logic [0:0]        cfg_grp = '0;
  logic [3:0]        cfg_bits = '0;
  logic              backup = 1'b0;
  logic [2*NCOM-1:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;
  logic [NSH-1:0]    port_in_en;

  lcd_mux_driver u_lcd_mux_driver (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_mode(wr_mode), .wr_digit(wr_digit), .wr_pattern(wr_pattern),
    .xfer_req(xfer_req), .cfg_we(cfg_we), .cfg_grp(cfg_grp),
    .cfg_bits(cfg_bits), .backup(backup), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .port_in_en(port_in_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   vectors = 0;
  int   miscompares = 0;
  int   k = 0;
  int   k_commit = 0;
  bit   armed = 0;
  bit   chk_en = 0;
  bit   bkp_m = 0;
  logic [3:0] disp_m [NSEG];
  logic [3:0] shad_m [NSEG];
  logic [NSH-1:0] cfg_m = '0;
  string phase = "R2";

  always @(posedge clk) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  task automatic tally(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s k=%0d actual %h expected %h", tag, k, act, exp);
    end
  endtask

  // cycle model from the requirements; sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && chk_en && k > 0) begin
      logic [2*NCOM-1:0] ec;
      logic [2*NSEG-1:0] es;
      logic [NSH-1:0]    ep;
      int                slot, sel;
      bit                neg;
      logic [3:0]        pat;
      ep = bkp_m ? '0 : cfg_m;
      slot = ((k - 1) / SLOT) % 8;
      neg  = (slot >= 4);
      sel  = slot % 4;
      for (int c = 0; c < NCOM; c++) begin
        if (bkp_m || k < FRAME + 1) ec[2*c +: 2] = 2'b00;
        else if (c == sel)          ec[2*c +: 2] = neg ? 2'b00 : 2'b10;
        else                        ec[2*c +: 2] = 2'b01;
      end
      for (int s = 0; s < NSEG; s++) begin
        pat = (armed && k > k_commit) ? shad_m[s] : disp_m[s];
        if (s >= SHB && s < SHB + NSH && cfg_m[s - SHB]) es[2*s +: 2] = 2'b11;
        else if (bkp_m || k < FRAME + 1)                 es[2*s +: 2] = 2'b00;
        else if (pat[sel])                               es[2*s +: 2] = neg ? 2'b10 : 2'b00;
        else                                             es[2*s +: 2] = neg ? 2'b00 : 2'b10;
      end
      if (bkp_m) begin
        tally(com_lvl == ec, {"R10 commons ", phase}, 64'(com_lvl), 64'(ec));
        tally(seg_lvl == es, {"R10 segments ", phase}, 64'(seg_lvl), 64'(es));
        tally(port_in_en == ep, {"R10 port_in_en ", phase}, 64'(port_in_en), 64'(ep));
      end else if (k < FRAME + 1) begin
        tally(com_lvl == ec, {"R2 commons ", phase}, 64'(com_lvl), 64'(ec));
        tally(seg_lvl == es, {"R2 segments ", phase}, 64'(seg_lvl), 64'(es));
        tally(port_in_en == ep, {"R9 port_in_en ", phase}, 64'(port_in_en), 64'(ep));
      end else begin
        tally(com_lvl == ec, {"R3 R4 commons ", phase}, 64'(com_lvl), 64'(ec));
        tally(seg_lvl == es, {"R5 segments ", phase}, 64'(seg_lvl), 64'(es));
        tally(port_in_en == ep, {"R9 port_in_en ", phase}, 64'(port_in_en), 64'(ep));
      end
    end
  end

  task automatic put(input bit mode, input int d, input logic [3:0] p);
    @(posedge clk); #1;
    chk_en = 0; wr_valid = 1; wr_mode = mode; wr_digit = 5'(d); wr_pattern = p;
    @(posedge clk); #1;
    wr_valid = 0; wr_mode = 0;
    if (mode) shad_m[d] = p; else disp_m[d] = p;
    @(posedge clk); #1;
    chk_en = 1;
  endtask

  task automatic kick();
    @(posedge clk); #1;
    xfer_req = 1;
    @(posedge clk); #1;
    xfer_req = 0;
    k_commit = (k / FRAME + 1) * FRAME;
    armed = 1;
  endtask

  task automatic set_ports(input int grp, input logic [3:0] b);
    @(posedge clk); #1;
    chk_en = 0; cfg_we = 1; cfg_grp = 1'(grp); cfg_bits = b;
    @(posedge clk); #1;
    cfg_we = 0;
    cfg_m[grp*4 +: 4] = b;
    @(posedge clk); #1;
    chk_en = 1;
  endtask

  task automatic set_backup(input bit v);
    @(posedge clk); #1;
    chk_en = 0; backup = v;
    @(posedge clk); #1;
    bkp_m = v; chk_en = 1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic reset_check();
    @(posedge clk); #1;
    chk_en = 0; rst_n = 0;
    run(3);
    @(negedge clk);
    tally(com_lvl == '0, "R1 commons in reset", 64'(com_lvl), 64'd0);
    tally(seg_lvl == '0, "R1 segments in reset", 64'(seg_lvl), 64'd0);
    tally(port_in_en == '0, "R1 port_in_en in reset", 64'(port_in_en), 64'd0);
    tally(wr_ready == 1'b1, "R1 wr_ready in reset", 64'(wr_ready), 64'd1);
    for (int s = 0; s < NSEG; s++) begin
      disp_m[s] = '0;
      shad_m[s] = '0;
    end
    cfg_m = '0; armed = 0;
    @(posedge clk); #1;
    rst_n = 1; chk_en = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired (R3 timebase) actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSEG; s++) begin
      disp_m[s] = '0;
      shad_m[s] = '0;
    end
    reset_check();

    // R2: blank frame, patterns loaded meanwhile
    phase = "R2";
    for (int d = 0; d < NSEG; d++) put(0, d, 4'((d * 5 + 3) & 15));
    while (k < FRAME + 2) @(posedge clk);

    // R3 R4 R5: two full frames with distinct patterns
    phase = "R3 R4 R5";
    run(2 * FRAME);

    // R6: sweep every pattern on one digit, one frame each
    phase = "R6";
    for (int p = 0; p < 16; p++) begin
      put(0, 7, 4'(p));
      run(FRAME);
    end
    put(0, 25, 4'hF); // out-of-range digit is dropped
    run(SLOT);

    // R7: latched writes are invisible until the frame boundary
    phase = "R7";
    run(300);
    for (int d = 0; d < NSEG; d++) put(1, d, 4'((d * 11 + 6) & 15));
    run(SLOT);
    kick();

    // R8: latched write stalls while pending
    phase = "R8";
    @(posedge clk); #1;
    wr_valid = 1; wr_mode = 1; wr_digit = 5'd3; wr_pattern = ~shad_m[3];
    repeat (5) begin
      @(negedge clk);
      tally(wr_ready == 1'b0, "R8 latched ready while pending", 64'(wr_ready), 64'd0);
    end
    @(posedge clk); #1;
    wr_valid = 0; wr_mode = 0;
    @(negedge clk);
    tally(wr_ready == 1'b1, "R8 direct ready while pending", 64'(wr_ready), 64'd1);
    phase = "R7";
    while (k < k_commit + FRAME) @(posedge clk);
    #1;
    for (int d = 0; d < NSEG; d++) disp_m[d] = shad_m[d];
    armed = 0;
    wr_mode = 1;
    @(negedge clk);
    tally(wr_ready == 1'b1, "R8 latched ready after commit", 64'(wr_ready), 64'd1);
    @(posedge clk); #1;
    wr_mode = 0;

    // R9: per-bit release of shared pins
    phase = "R9";
    set_ports(0, 4'b0101);
    set_ports(1, 4'b1010);
    run(FRAME);
    set_ports(0, 4'b0000);
    run(FRAME);

    // R10: backup forcing and recovery
    phase = "R10";
    set_backup(1);
    run(300);
    set_backup(0);
    run(FRAME);

    // R1: reset mid-run clears patterns and ports, blank frame again
    reset_check();
    phase = "R1 R2";
    run(FRAME + 2 * SLOT);

    chk_en = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule